// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Status Register

This block holds the interrupt state of a real-time clock. Three event sources (periodic tick, alarm match, update-ended) each deliver a single-cycle pulse. Every pulse sets a sticky flag for its source, whatever the state of that source's enable. The flags can then be polled through a read-only status byte, or they can drive an active-low interrupt request when the matching enable, supplied by a separate control register, is set.

A host read is a level on a read strobe. When the strobe rises, the status byte is captured into a snapshot. The snapshot stays on the read data output without change until the next read starts. When the strobe falls, every flag is cleared. Events that arrive while the strobe is high are parked in a per-source holding bit. They are merged into the flags on the falling edge, so a read never loses an event and never clears one that it did not report.

Top module: `rtc_irq_status`

## Requirements
- R1: After a synchronous active-high reset, all flags and held events are clear, `irq_n_o` is 1 and `rd_data_o` is 0x00.
- R2: A pulse that arrives while the strobe is low sets its flag on the next clock, whatever the enable inputs are. In the status byte the periodic flag is bit 6, the alarm flag is bit 5 and the update-ended flag is bit 4.
- R3: On the clock where `rd_strobe_i` is first seen high, the status byte is captured. `rd_data_o` shows it from the next cycle and keeps it unchanged until the next rising edge of the strobe.
- R4: On the clock where `rd_strobe_i` is first seen low after being high, every flag that was set is cleared. As a result the summary bit and the interrupt request clear as well.
- R5: A pulse that arrives while the strobe is high does not appear in the current snapshot. It sets its flag on the falling-edge clock, so the next read reports it. A pulse that arrives on the falling-edge clock itself is also kept.
- R6: `irq_n_o` is 0 one clock after any source has both its flag and its enable set. It is 1 one clock after no source has both.
- R7: Status bit 7 (the summary bit) equals the inverse of `irq_n_o` as sampled at the capture clock.
- R8: Status bits 3 to 0 always read 0.
- R9: Changing an enable input moves `irq_n_o` on the next clock and leaves every flag unchanged.
- R10: Two or three flags can be reported set in a single snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_periodic_i | input | 1 | Periodic tick event pulse |
| evt_alarm_i | input | 1 | Alarm match event pulse |
| evt_update_i | input | 1 | Update-ended event pulse |
| en_periodic_i | input | 1 | Interrupt enable for the periodic source |
| en_alarm_i | input | 1 | Interrupt enable for the alarm source |
| en_update_i | input | 1 | Interrupt enable for the update-ended source |
| rd_strobe_i | input | 1 | Status read strobe, held high for the read cycle |
| rd_data_o | output | 8 | Status snapshot captured at the start of the last read |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest situation to reach is an event that collides with a read. A pulse can land on the very clock where the strobe rises, in the middle of a held read, or on the clock where the strobe falls. Each of these must reach the flags through a different path. The bench handles each collision in its own task, placing the pulse and the strobe edge at the same falling clock edge. It then checks that the snapshot did not move during the read, and that the following read reports exactly the parked events.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int unsigned STAT_W   = 8;
    localparam int unsigned N_SRC    = 3;
    localparam int unsigned FLAG_LSB = 4;
    localparam int unsigned SUM_BIT  = 7;

    // Source order inside flag vectors: index 0 update, 1 alarm, 2 periodic.
    localparam int unsigned SRC_UPD = 0;
    localparam int unsigned SRC_ALM = 1;
    localparam int unsigned SRC_PER = 2;

    typedef struct packed {
        logic flag;
        logic held;
    } cell_st_t;

    typedef struct packed {
        logic              strobe;
        logic [STAT_W-1:0] snap;
    } rd_st_t;

    typedef struct packed {
        logic irq_n;
    } drv_st_t;

endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell
    import rtc_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic evt_i,
    input  logic rd_busy_i,
    input  logic rd_fall_i,
    output logic flag_o
);

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_busy_i) begin
            if (evt_i) begin
                st_d.held = 1'b1;
            end
        end else if (rd_fall_i) begin
            st_d.flag = st_q.held | evt_i;
            st_d.held = 1'b0;
        end else if (evt_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    p_poll_set_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rd_busy_i && evt_i) |=> flag_o);

    p_hold_in_read_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_busy_i |=> (flag_o == $past(flag_o)));

    p_merge_on_end_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_fall_i |=> (flag_o == $past(st_q.held | evt_i)) && !st_q.held);

    p_clear_on_end_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_fall_i && !st_q.held && !evt_i) |=> !flag_o);

endmodule

// File: rtl/rtc_rd_ctrl.sv
module rtc_rd_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NSRC  = N_SRC,
    parameter int unsigned DW    = STAT_W,
    parameter int unsigned F_LSB = FLAG_LSB,
    parameter int unsigned S_BIT = SUM_BIT
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            strobe_i,
    input  logic [NSRC-1:0] flags_i,
    input  logic            irq_n_i,
    output logic            busy_o,
    output logic            rise_o,
    output logic            fall_o,
    output logic [DW-1:0]   data_o
);

    rd_st_t st_d, st_q;
    logic [DW-1:0] status_now;

    always_comb begin
        status_now = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            status_now[F_LSB+i] = flags_i[i];
        end
        status_now[S_BIT] = ~irq_n_i;
    end

    assign busy_o = strobe_i;
    assign rise_o = strobe_i & ~st_q.strobe;
    assign fall_o = ~strobe_i & st_q.strobe;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = strobe_i;
        if (rise_o) begin
            st_d.snap = status_now;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.snap;

    p_snap_stable_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise_o |=> $stable(data_o));

    p_low_bits_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> (data_o[F_LSB-1:0] == '0));

endmodule

// File: rtl/rtc_irq_drive.sv
module rtc_irq_drive
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NSRC = N_SRC
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    output logic            irq_n_o
);

    drv_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~(|(flags_i & en_i));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{irq_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n_o = st_q.irq_n;

    p_irq_assert_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(flags_i & en_i)) |=> !irq_n_o);

    p_irq_release_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|(flags_i & en_i)) |=> irq_n_o);

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
#(
    parameter int unsigned DW    = STAT_W,
    parameter int unsigned F_LSB = FLAG_LSB,
    parameter int unsigned S_BIT = SUM_BIT
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          evt_periodic_i,
    input  logic          evt_alarm_i,
    input  logic          evt_update_i,
    input  logic          en_periodic_i,
    input  logic          en_alarm_i,
    input  logic          en_update_i,
    input  logic          rd_strobe_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_n_o
);

    localparam int unsigned NSRC = N_SRC;

    logic [NSRC-1:0] src_evt;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] src_flag;
    logic            rd_busy;
    logic            rd_rise;
    logic            rd_fall;

    always_comb begin
        src_evt          = '0;
        src_en           = '0;
        src_evt[SRC_PER] = evt_periodic_i;
        src_evt[SRC_ALM] = evt_alarm_i;
        src_evt[SRC_UPD] = evt_update_i;
        src_en[SRC_PER]  = en_periodic_i;
        src_en[SRC_ALM]  = en_alarm_i;
        src_en[SRC_UPD]  = en_update_i;
    end

    for (genvar g = 0; g < int'(NSRC); g++) begin : g_cell
        rtc_flag_cell u_cell (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .evt_i     (src_evt[g]),
            .rd_busy_i (rd_busy),
            .rd_fall_i (rd_fall),
            .flag_o    (src_flag[g])
        );
    end

    rtc_rd_ctrl #(
        .NSRC  (NSRC),
        .DW    (DW),
        .F_LSB (F_LSB),
        .S_BIT (S_BIT)
    ) u_rd (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (rd_strobe_i),
        .flags_i  (src_flag),
        .irq_n_i  (irq_n_o),
        .busy_o   (rd_busy),
        .rise_o   (rd_rise),
        .fall_o   (rd_fall),
        .data_o   (rd_data_o)
    );

    rtc_irq_drive #(
        .NSRC (NSRC)
    ) u_drv (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flags_i (src_flag),
        .en_i    (src_en),
        .irq_n_o (irq_n_o)
    );

    p_summary_bit_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_rise |=> (rd_data_o[S_BIT] == !$past(irq_n_o)));

    p_enable_keeps_flags_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rd_busy && !rd_fall && (src_evt == '0)) |=> (src_flag == $past(src_flag)));

endmodule

// File: tb/rtc_irq_status_tb_top.sv
module rtc_irq_status_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ev_p, ev_a, ev_u;
    logic       en_p, en_a, en_u;
    logic       rd;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtc_irq_status dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .evt_periodic_i (ev_p),
        .evt_alarm_i    (ev_a),
        .evt_update_i   (ev_u),
        .en_periodic_i  (en_p),
        .en_alarm_i     (en_a),
        .en_update_i    (en_u),
        .rd_strobe_i    (rd),
        .rd_data_o      (rd_data),
        .irq_n_o        (irq_n)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // pulse given sources for one cycle; flags are set after the next edge
    task automatic pulse(input logic p, input logic a, input logic u);
        ev_p = p; ev_a = a; ev_u = u;
        step();
        ev_p = 0; ev_a = 0; ev_u = 0;
    endtask

    // full read: idle cycle, strobe high two cycles, strobe low
    task automatic do_read(output logic [7:0] val);
        step();
        rd = 1'b1;
        step();
        val = rd_data;
        step();
        rd = 1'b0;
        step();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        chk("R1 rd_data after reset", rd_data, 8'h00);
        do_read(v);
        chk("R1 first read empty", v, 8'h00);
        chk("R8 low bits zero", v & 8'h0F, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        pulse(1, 0, 0);
        step();
        chk("R2 irq stays high with enables off", {7'd0, irq_n}, 8'h01);
        do_read(v);
        chk("R2 periodic flag at bit 6", v, 8'h40);
        do_read(v);
        chk("R4 flag cleared by read", v, 8'h00);
        pulse(0, 1, 0);
        do_read(v);
        chk("R2 alarm flag at bit 5", v, 8'h20);
        pulse(0, 0, 1);
        do_read(v);
        chk("R2 update flag at bit 4", v, 8'h10);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        en_a = 1'b1;
        pulse(0, 1, 0);
        chk("R6 irq not yet low one cycle after pulse", {7'd0, irq_n}, 8'h01);
        step();
        chk("R6 irq low with flag and enable", {7'd0, irq_n}, 8'h00);
        do_read(v);
        chk("R7 summary bit set with alarm", v, 8'hA0);
        step();
        chk("R4 irq released after read", {7'd0, irq_n}, 8'h01);
        do_read(v);
        chk("R4 summary cleared", v, 8'h00);
        en_a = 1'b0;
    endtask

    task automatic t_multi();
        logic [7:0] v;
        en_u = 1'b1;
        pulse(1, 1, 1);
        do_read(v);
        chk("R10 three flags plus summary", v, 8'hF0);
        en_u = 1'b0;
        pulse(1, 0, 1);
        do_read(v);
        chk("R10 two flags no summary", v, 8'h50);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pulse(1, 0, 0);
        step();
        rd = 1'b1; ev_a = 1'b1;      // event on the rising-edge clock
        step();
        ev_a = 1'b0;
        chk("R5 rising-edge event not in snapshot", rd_data, 8'h40);
        ev_u = 1'b1;                 // event in the middle of the read
        step();
        ev_u = 1'b0;
        chk("R3 snapshot stable during read", rd_data, 8'h40);
        step();
        chk("R3 snapshot still stable", rd_data, 8'h40);
        rd = 1'b0;
        step();
        chk("R3 snapshot held after read ends", rd_data, 8'h40);
        do_read(v);
        chk("R5 held events reported next read", v, 8'h30);
        // event on the falling-edge clock
        step();
        rd = 1'b1;
        step();
        step();
        rd = 1'b0; ev_p = 1'b1;
        step();
        ev_p = 1'b0;
        do_read(v);
        chk("R5 falling-edge event kept", v, 8'h40);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        pulse(0, 0, 1);
        step();
        chk("R9 irq high with enable off", {7'd0, irq_n}, 8'h01);
        en_u = 1'b1;
        step();
        chk("R9 irq low one clock after enable", {7'd0, irq_n}, 8'h00);
        en_u = 1'b0;
        step();
        chk("R9 irq high one clock after disable", {7'd0, irq_n}, 8'h01);
        do_read(v);
        chk("R9 flag unchanged by enable toggling", v, 8'h10);
    endtask

    initial begin
        rst = 1'b1; rd = 0;
        ev_p = 0; ev_a = 0; ev_u = 0;
        en_p = 0; en_a = 0; en_u = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_poll();
        t_irq();
        t_multi();
        t_collide();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule